// File: doc/BRIEF.md
# Pipelined Tower-Field AES Byte Substitution

This block performs the forward AES byte substitution on one byte per clock without any lookup table. Each incoming byte is moved by a fixed XOR network into a tower-field representation in which GF(2^8) is a degree-two extension of GF(2^4), and GF(2^4) is in turn a degree-two extension of GF(2^2). The multiplicative inverse is formed there out of small nibble and dibit operators. The result is mapped back to the standard polynomial basis and passed through the AES affine step.

The datapath is cut into four register stages: basis change, the nibble determinant, the nibble inverse, and the final products with back-mapping and affine step. A new byte may be offered on every cycle. Each result leaves with a valid flag after a fixed delay. Stage registers load only when a valid byte passes through them, so the output holds its last result while no valid byte is arriving.

Top module: `sbox_pipe`

## Requirements
- R1: While rst_ni is low, and after release until the first valid byte leaves, valid_o is 0 and data_o is 8'h00.
- R2: valid_o equals the valid_i value sampled on the rising edge four edges earlier, that is, a byte sampled on edge n is reflected on the outputs right after edge n+3.
- R3: When valid_o is 1, data_o equals the AES forward substitution of the data_i byte sampled together with the matching valid_i; the substitution is the GF(2^8) inverse modulo x^8+x^4+x^3+x+1 (zero mapped to zero) followed by s[i] = b[i]^b[i+4]^b[i+5]^b[i+6]^b[i+7]^c[i] with indices mod 8 and c = 8'h63. This holds for all 256 input values.
- R4: An input of 8'h00 produces 8'h63.
- R5: Valid bytes offered on consecutive cycles each produce a result on consecutive cycles, with no stall or loss.
- R6: A data_i value offered with valid_i low has no effect: while valid_o is 0, data_o keeps the last valid result.
- R7: Asserting rst_ni low in the middle of a stream discards every byte in flight: valid_o and data_o go to 0 at once and no discarded byte ever appears as a valid output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Marks data_i as a byte to substitute |
| data_i | input | 8 | Byte to substitute |
| valid_o | output | 1 | Marks data_o as a fresh result |
| data_o | output | 8 | Substituted byte |

## Verification
A byte sampled on a rising edge has its result and flag on the outputs after the third following edge, so the bench drives on falling edges and keeps its own four-deep expected pipeline, comparing the outputs at each falling edge against the entry pushed four drives earlier. Results are computed in the bench by a behavioural field model using exponentiation to the power 254, and a separate last-result register predicts data_o during bubbles. Reset is checked one nanosecond after it is asserted, before any clock edge, to confirm the flush is immediate.

// File: rtl/sbox_pkg.sv
`timescale 1ns/1ps
package sbox_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NIB_W     = BYTE_W / 2;
  localparam int unsigned DIB_W     = NIB_W / 2;
  localparam int unsigned N_STAGES  = 4;
  localparam logic [BYTE_W-1:0] AFF_C = 8'h63;

  typedef logic [DIB_W-1:0]  gf4_t;
  typedef logic [NIB_W-1:0]  gf16_t;
  typedef logic [BYTE_W-1:0] gf256_t;

  // GF(2^2) product, modulus x^2+x+1, three-AND form
  function automatic gf4_t gf4_mul(gf4_t q, gf4_t w);
    gf4_t k;
    k[1] = ((q[1] ^ q[0]) & (w[1] ^ w[0])) ^ (q[0] & w[0]);
    k[0] = (q[1] & w[1]) ^ (q[0] & w[0]);
    return k;
  endfunction

  // scale by phi = 2'b10
  function automatic gf4_t gf4_mul_phi(gf4_t q);
    return {q[1] ^ q[0], q[1]};
  endfunction

  function automatic gf16_t gf16_sq(gf16_t q);
    return {q[3], q[3] ^ q[2], q[2] ^ q[1], q[3] ^ q[1] ^ q[0]};
  endfunction

  // scale by lambda = 4'b1100
  function automatic gf16_t gf16_mul_lambda(gf16_t q);
    return {q[2] ^ q[0], q[3] ^ q[2] ^ q[1] ^ q[0], q[3], q[2]};
  endfunction

  function automatic gf256_t aes_affine(gf256_t b);
    gf256_t s;
    for (int i = 0; i < BYTE_W; i++) begin
      s[i] = b[i] ^ b[(i+4)%BYTE_W] ^ b[(i+5)%BYTE_W] ^ b[(i+6)%BYTE_W]
           ^ b[(i+7)%BYTE_W] ^ AFF_C[i];
    end
    return s;
  endfunction

endpackage

// File: rtl/sbox_iso_map.sv
`timescale 1ns/1ps
module sbox_iso_map
  import sbox_pkg::*;
#(
  parameter bit TO_STD = 1'b0  // 0: standard -> tower, 1: tower -> standard
) (
  input  gf256_t q_i,
  output gf256_t a_o
);
  generate
    if (!TO_STD) begin : g_fwd
      assign a_o[7] = q_i[7] ^ q_i[5];
      assign a_o[6] = q_i[7] ^ q_i[6] ^ q_i[4] ^ q_i[3] ^ q_i[2] ^ q_i[1];
      assign a_o[5] = q_i[7] ^ q_i[5] ^ q_i[3] ^ q_i[2];
      assign a_o[4] = q_i[7] ^ q_i[5] ^ q_i[3] ^ q_i[2] ^ q_i[1];
      assign a_o[3] = q_i[7] ^ q_i[6] ^ q_i[2] ^ q_i[1];
      assign a_o[2] = q_i[7] ^ q_i[4] ^ q_i[3] ^ q_i[2] ^ q_i[1];
      assign a_o[1] = q_i[6] ^ q_i[4] ^ q_i[1];
      assign a_o[0] = q_i[6] ^ q_i[1] ^ q_i[0];
    end else begin : g_bwd
      assign a_o[7] = q_i[7] ^ q_i[6] ^ q_i[5] ^ q_i[1];
      assign a_o[6] = q_i[6] ^ q_i[2];
      assign a_o[5] = q_i[6] ^ q_i[5] ^ q_i[1];
      assign a_o[4] = q_i[6] ^ q_i[5] ^ q_i[4] ^ q_i[2] ^ q_i[1];
      assign a_o[3] = q_i[5] ^ q_i[4] ^ q_i[3] ^ q_i[2] ^ q_i[1];
      assign a_o[2] = q_i[7] ^ q_i[4] ^ q_i[3] ^ q_i[2] ^ q_i[1];
      assign a_o[1] = q_i[5] ^ q_i[4];
      assign a_o[0] = q_i[6] ^ q_i[5] ^ q_i[4] ^ q_i[2] ^ q_i[0];
    end
  endgenerate
endmodule

// File: rtl/sbox_gf16_mul.sv
`timescale 1ns/1ps
module sbox_gf16_mul
  import sbox_pkg::*;
(
  input  gf16_t a_i,
  input  gf16_t b_i,
  output gf16_t p_o
);
  gf4_t hh, ll, mid;

  // Karatsuba split: three dibit products
  assign hh  = gf4_mul(a_i[3:2], b_i[3:2]);
  assign ll  = gf4_mul(a_i[1:0], b_i[1:0]);
  assign mid = gf4_mul(a_i[3:2] ^ a_i[1:0], b_i[3:2] ^ b_i[1:0]);

  assign p_o = {mid ^ ll, gf4_mul_phi(hh) ^ ll};
endmodule

// File: rtl/sbox_gf16_inv.sv
`timescale 1ns/1ps
module sbox_gf16_inv
  import sbox_pkg::*;
(
  input  gf16_t q_i,
  output gf16_t inv_o
);
  logic q3, q2, q1, q0;
  logic t321, t320, t310, t30, t31, t21, t20, t210;

  assign {q3, q2, q1, q0} = q_i;

  assign t321 = q3 & q2 & q1;
  assign t320 = q3 & q2 & q0;
  assign t310 = q3 & q1 & q0;
  assign t210 = q2 & q1 & q0;
  assign t30  = q3 & q0;
  assign t31  = q3 & q1;
  assign t21  = q2 & q1;
  assign t20  = q2 & q0;

  assign inv_o[3] = q3 ^ t321 ^ t30 ^ q2;
  assign inv_o[2] = t321 ^ t320 ^ t30 ^ q2 ^ t21;
  assign inv_o[1] = q3 ^ t321 ^ t310 ^ q2 ^ t20 ^ q1;
  assign inv_o[0] = t321 ^ t320 ^ t31 ^ t310 ^ t30 ^ q2 ^ t21 ^ t210 ^ q1 ^ q0;
endmodule

// File: rtl/sbox_pipe.sv
`timescale 1ns/1ps
module sbox_pipe
  import sbox_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  output logic       valid_o,
  output logic [7:0] data_o
);
  logic [N_STAGES-1:0] vld_q;

  // stage 1: basis change
  gf256_t iso;
  gf16_t  s1_hi_q, s1_lo_q;

  // stage 2: determinant d = lambda*hi^2 + lo*(hi+lo)
  gf16_t  s1_sum, s1_prod, s1_det;
  gf16_t  s2_det_q, s2_hi_q, s2_sum_q;

  // stage 3: nibble inverse
  gf16_t  s2_inv;
  gf16_t  s3_inv_q, s3_hi_q, s3_sum_q;

  // stage 4: products, back-mapping, affine
  gf16_t  s3_out_hi, s3_out_lo;
  gf256_t s3_std;
  gf256_t out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[N_STAGES-2:0], valid_i};
  end

  sbox_iso_map #(.TO_STD(1'b0)) u_map_in (.q_i(data_i), .a_o(iso));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_hi_q <= '0;
      s1_lo_q <= '0;
    end else if (valid_i) begin
      s1_hi_q <= iso[7:4];
      s1_lo_q <= iso[3:0];
    end
  end

  assign s1_sum = s1_hi_q ^ s1_lo_q;

  sbox_gf16_mul u_mul_det (.a_i(s1_lo_q), .b_i(s1_sum), .p_o(s1_prod));

  assign s1_det = gf16_mul_lambda(gf16_sq(s1_hi_q)) ^ s1_prod;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_det_q <= '0;
      s2_hi_q  <= '0;
      s2_sum_q <= '0;
    end else if (vld_q[0]) begin
      s2_det_q <= s1_det;
      s2_hi_q  <= s1_hi_q;
      s2_sum_q <= s1_sum;
    end
  end

  sbox_gf16_inv u_inv (.q_i(s2_det_q), .inv_o(s2_inv));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s3_inv_q <= '0;
      s3_hi_q  <= '0;
      s3_sum_q <= '0;
    end else if (vld_q[1]) begin
      s3_inv_q <= s2_inv;
      s3_hi_q  <= s2_hi_q;
      s3_sum_q <= s2_sum_q;
    end
  end

  sbox_gf16_mul u_mul_hi (.a_i(s3_hi_q),  .b_i(s3_inv_q), .p_o(s3_out_hi));
  sbox_gf16_mul u_mul_lo (.a_i(s3_sum_q), .b_i(s3_inv_q), .p_o(s3_out_lo));

  sbox_iso_map #(.TO_STD(1'b1)) u_map_out (.q_i({s3_out_hi, s3_out_lo}), .a_o(s3_std));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       out_q <= '0;
    else if (vld_q[2]) out_q <= aes_affine(s3_std);
  end

  assign valid_o = vld_q[N_STAGES-1];
  assign data_o  = out_q;
endmodule

// File: rtl/sbox_pipe_chk.sv
`timescale 1ns/1ps
module sbox_pipe_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [7:0] data_i,
  input logic       valid_o,
  input logic [7:0] data_o
);
  localparam int unsigned DEPTH = 4;

  logic [DEPTH-1:0] ref_v_q;
  logic [7:0]       ref_d_q [DEPTH];
  logic [7:0]       ref_exp;

  function automatic logic [7:0] m_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p = '0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] m_sbox(logic [7:0] a);
    logic [7:0] r = 8'h01;
    logic [7:0] s;
    for (int i = 0; i < 254; i++) r = m_mul(r, a);
    for (int i = 0; i < 8; i++)
      s[i] = r[i] ^ r[(i+4)%8] ^ r[(i+5)%8] ^ r[(i+6)%8] ^ r[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
    return s;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_v_q <= '0;
      for (int i = 0; i < DEPTH; i++) ref_d_q[i] <= '0;
    end else begin
      ref_v_q    <= {ref_v_q[DEPTH-2:0], valid_i};
      ref_d_q[0] <= data_i;
      for (int i = 1; i < DEPTH; i++) ref_d_q[i] <= ref_d_q[i-1];
    end
  end

  assign ref_exp = m_sbox(ref_d_q[DEPTH-1]);

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (!valid_o && data_o == 8'h00)
        else $error("outputs not cleared in reset");
    end
  end

  // R2
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == ref_v_q[DEPTH-1]);

  // R3
  subst_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> data_o == ref_exp);

  // R4
  zero_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ref_d_q[DEPTH-1] == 8'h00) |-> data_o == 8'h63);

  // R6
  bubble_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));
endmodule

bind sbox_pipe sbox_pipe_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .data_i (data_i),
  .valid_o(valid_o),
  .data_o (data_o)
);

// File: tb/sbox_pipe_tb.sv
`timescale 1ns/1ps
module sbox_pipe_tb;
  localparam int unsigned LAT    = 4;
  localparam int unsigned WD_CYC = 200000;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       valid_i;
  logic [7:0] data_i;
  logic       valid_o;
  logic [7:0] data_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic       pv [LAT];
  logic [7:0] pd [LAT];
  logic [7:0] last_res;

  always #2 clk = ~clk;

  sbox_pipe u_dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .data_i (data_i),
    .valid_o(valid_o),
    .data_o (data_o)
  );

  function automatic logic [7:0] tb_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] p = '0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] tb_sbox(logic [7:0] a);
    logic [7:0] r = 8'h01;
    logic [7:0] c = 8'h63;
    logic [7:0] s;
    for (int i = 0; i < 254; i++) r = tb_mul(r, a);
    for (int i = 0; i < 8; i++)
      s[i] = r[i] ^ r[(i+4)%8] ^ r[(i+5)%8] ^ r[(i+6)%8] ^ r[(i+7)%8] ^ c[i];
    return s;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < LAT; i++) begin
      pv[i] = 1'b0;
      pd[i] = 8'h00;
    end
    last_res = 8'h00;
  endtask

  // one cycle: check outputs due now, then drive the next input
  task automatic step(input logic v, input logic [7:0] d, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    if (pv[LAT-1]) begin
      exp      = tb_sbox(pd[LAT-1]);
      last_res = exp;
    end else begin
      exp = last_res;
    end
    check({tag, " valid"}, {7'd0, valid_o}, {7'd0, pv[LAT-1]});
    check({tag, " data"}, data_o, exp);
    for (int i = LAT-1; i > 0; i--) begin
      pv[i] = pv[i-1];
      pd[i] = pd[i-1];
    end
    pv[0]   = v;
    pd[0]   = d;
    valid_i = v;
    data_i  = d;
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    #1;
    check({tag, " rst valid"}, {7'd0, valid_o}, 8'h00);
    check({tag, " rst data"}, data_o, 8'h00);
    repeat (2) @(negedge clk);
    check({tag, " held valid"}, {7'd0, valid_o}, 8'h00);
    check({tag, " held data"}, data_o, 8'h00);
    rst_ni = 1'b1;
    clear_model();
  endtask

  task automatic t_reset_idle();
    do_reset("R1");
    for (int i = 0; i < 6; i++) step(1'b0, 8'h5a + 8'(i), "R1");
  endtask

  task automatic t_zero();
    step(1'b1, 8'h00, "R4");
    for (int i = 0; i < LAT; i++) step(1'b0, 8'hff, "R4");
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 256; i++) step(1'b1, 8'(i), "R3 R5");
    for (int i = 0; i < LAT; i++) step(1'b0, 8'h00, "R3 R5");
  endtask

  task automatic t_sparse();
    for (int i = 0; i < 24; i++) begin
      step(1'b1, 8'(i * 37 + 11), "R2");
      step(1'b0, 8'(i * 91) ^ 8'ha5, "R6");
      if (i % 3 == 0) step(1'b0, 8'hc3, "R6");
    end
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 8'h3c, "R6");
  endtask

  task automatic t_midreset();
    step(1'b1, 8'h53, "R7");
    step(1'b1, 8'hca, "R7");
    step(1'b1, 8'h01, "R7");
    do_reset("R7");
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 8'h77, "R7");
    step(1'b1, 8'h10, "R7");
    for (int i = 0; i < LAT; i++) step(1'b0, 8'h00, "R7");
  endtask

  initial begin
    #(WD_CYC * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_ni  = 1'b1;
    valid_i = 1'b0;
    data_i  = 8'h00;
    clear_model();
    #1 rst_ni = 1'b0;
    t_reset_idle();
    t_zero();
    t_sweep();
    t_sparse();
    t_midreset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule